// File: doc/BRIEF.md
# Sub-Word Data Memory

This block is the data store of a 32-bit processor. It is byte addressed and holds 2^ADDR_W bytes, organised as 32-bit words with four byte lanes. One port carries a read enable, a write enable, a 2-bit access size, a byte address and write data, and a registered 32-bit read-data output.

A load delivers its result one clock after it is presented. Halfword and byte loads are zero-extended. Halfword and byte stores change only the lanes they cover, so the rest of the word keeps its contents. A cycle with both enables set is a read only.

The address wraps modulo the memory size. Storage is little-endian.

Top module: `subword_dmem`

## Requirements
- R1: The access size is coded on `acc_size`: 00 selects a 32-bit word, 01 a 16-bit halfword and 10 an 8-bit byte.
- R2: A word load returns the four bytes of the addressed word, with byte offset 0 in bits 7:0. Address bits [1:0] are ignored.
- R3: A halfword load returns the halfword picked by address bit [1] in bits 15:0, with bits 31:16 zero. Bit [1] = 1 picks word bits 31:16. Address bit [0] is ignored.
- R4: A byte load returns the byte at offset address[1:0] in bits 7:0, with bits 31:8 zero. Offset k is word bits 8k+7:8k.
- R5: Read data for a load presented in cycle n appears after the rising edge that ends cycle n. It then holds its value for as long as `rd_en` stays low.
- R6: A store happens at the clock edge only when `wr_en` = 1 and `rd_en` = 0. When both are 1, memory is not changed and the cycle acts as a load.
- R7: A halfword store writes `wr_data[15:0]` into the halfword picked by address bit [1]. The other two bytes of the word are unchanged.
- R8: A byte store writes `wr_data[7:0]` into the byte at offset address[1:0]. The other three bytes are unchanged.
- R9: Size code 11 behaves exactly as a word access, for both loads and stores.
- R10: Only address bits [ADDR_W-1:0] are used, so addresses that differ only above that bit reach the same byte.
- R11: While `rst_n` is low, and after it is released until the first load, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read-data register |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Store data, taken from the low lanes for sub-word stores |
| rd_en | input | 1 | Load request |
| wr_en | input | 1 | Store request, taken only when `rd_en` is low |
| acc_size | input | 2 | Access size code |
| rd_data | output | 32 | Registered load result |

## Verification
Every load result is due exactly one rising edge after the load is presented. The bench therefore drives each operation on a falling edge, lets one rising edge pass and samples `rd_data` on the next falling edge.

A store has no visible result of its own. It is judged later, by loads of the same word checked against a byte-level model in the bench. In store-only cycles and idle cycles, the sample must still equal the previous load result.

Stores that overlap in time with a load are caught the same way. The bench reads the word back on the following cycle and compares it with the unchanged model.

// File: rtl/subword_dmem_pkg.sv
package subword_dmem_pkg;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  // Byte lanes touched by an access of size sz at byte offset off
  function automatic logic [3:0] lane_strobes(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
      SZ_BYTE: return 4'b0001 << off;
      default: return 4'b1111;
    endcase
  endfunction

  // Replicate the low lanes so that any selected lane sees the right data
  function automatic logic [31:0] lane_place(input logic [1:0] sz, input logic [31:0] wd);
    case (sz)
      SZ_HALF: return {2{wd[15:0]}};
      SZ_BYTE: return {4{wd[7:0]}};
      default: return wd;
    endcase
  endfunction

  // Select and zero-extend the loaded portion of a word
  function automatic logic [31:0] lane_extract(input logic [1:0] sz, input logic [1:0] off,
                                               input logic [31:0] word);
    logic [31:0] shifted;
    shifted = word >> {off, 3'b000};
    case (sz)
      SZ_HALF: return {16'h0000, off[1] ? word[31:16] : word[15:0]};
      SZ_BYTE: return {24'h000000, shifted[7:0]};
      default: return word;
    endcase
  endfunction

endpackage

// File: rtl/dmem_lane_ctrl.sv
module dmem_lane_ctrl
  import subword_dmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WIDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic [WIDX_W-1:0] widx_o,
  output logic [1:0]        off_o,
  output logic [3:0]        be_o,
  output logic [31:0]       wword_o
);

  logic store_go;

  assign store_go = wr_en_i && !rd_en_i;
  assign widx_o   = addr_i[ADDR_W-1:2];
  assign off_o    = addr_i[1:0];
  assign be_o     = store_go ? lane_strobes(size_i, addr_i[1:0]) : 4'b0000;
  assign wword_o  = lane_place(size_i, wdata_i);

endmodule

// File: rtl/dmem_byte_array.sv
module dmem_byte_array #(
  parameter int WIDX_W = 8,
  localparam int WORDS = 2 ** WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wword_i,
  output logic [31:0]       rword_o
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] store_q [WORDS];
    logic [7:0] rbyte_q;

    always_ff @(posedge clk) begin
      if (be_i[g]) store_q[widx_i] <= wword_i[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rbyte_q <= 8'h00;
      else if (rd_en_i) rbyte_q <= store_q[widx_i];
    end

    assign rword_o[8*g +: 8] = rbyte_q;
  end

endmodule

// File: rtl/dmem_load_fmt.sv
module dmem_load_fmt
  import subword_dmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] rword_i,
  output logic [31:0] rdata_o
);

  logic [1:0] sz_q;
  logic [1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_q  <= SZ_WORD;
      off_q <= 2'b00;
    end else if (rd_en_i) begin
      sz_q  <= size_i;
      off_q <= off_i;
    end
  end

  assign rdata_o = lane_extract(sz_q, off_q, rword_i);

  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && size_i == SZ_HALF) |=> (rdata_o[31:16] == 16'h0000)); // R3
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && size_i == SZ_BYTE) |=> (rdata_o[31:8] == 24'h000000)); // R4

endmodule

// File: rtl/subword_dmem.sv
module subword_dmem
  import subword_dmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WIDX_W = ADDR_W - 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  acc_size,
  output logic [31:0] rd_data
);

  logic [WIDX_W-1:0] widx;
  logic [1:0]        off;
  logic [3:0]        be;
  logic [31:0]       wword;
  logic [31:0]       rword;
  logic              unused_addr_hi;

  // R10: upper address bits wrap onto the same storage
  assign unused_addr_hi = ^addr[31:ADDR_W];

  dmem_lane_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .addr_i  (addr[ADDR_W-1:0]),
    .wdata_i (wr_data),
    .size_i  (acc_size),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .widx_o  (widx),
    .off_o   (off),
    .be_o    (be),
    .wword_o (wword)
  );

  dmem_byte_array #(.WIDX_W(WIDX_W)) array_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en),
    .widx_i  (widx),
    .be_i    (be),
    .wword_i (wword),
    .rword_o (rword)
  );

  dmem_load_fmt fmt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en),
    .size_i  (acc_size),
    .off_i   (off),
    .rword_i (rword),
    .rdata_o (rd_data)
  );

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R5
  AST_NO_STORE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (be == 4'b0000)); // R6
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && acc_size == SZ_HALF) |-> ($countones(be) == 2 && (be == 4'b0011 || be == 4'b1100))); // R7
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && acc_size == SZ_BYTE) |-> $onehot0(be) && (be != 4'b0000)); // R8
  AST_WIDE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && acc_size[0] == acc_size[1]) |-> (be == 4'b1111)); // R9

endmodule

// File: tb/subword_dmem_tb_top.sv
module subword_dmem_tb_top;

  localparam int AW = 10;
  localparam int NBYTES = 2 ** AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0]  model [NBYTES];
  logic [31:0] exp_rd = 32'h0;

  always #2 clk = ~clk;

  subword_dmem #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .acc_size(acc_size), .rd_data(rd_data)
  );

  // First byte address of the lanes covered by an access
  function automatic int first_byte(input logic [31:0] a, input logic [1:0] sz);
    int w;
    w = int'(a % NBYTES) & ~3;
    if (sz == 2'b01) return w + (a[1] ? 2 : 0);
    if (sz == 2'b10) return w + int'(a[1:0]);
    return w;
  endfunction

  function automatic int span(input logic [1:0] sz);
    if (sz == 2'b01) return 2;
    if (sz == 2'b10) return 1;
    return 4;
  endfunction

  function automatic logic [31:0] model_load(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v;
    int b;
    v = 32'h0;
    b = first_byte(a, sz);
    for (int i = 0; i < span(sz); i++) v[8*i +: 8] = model[b + i];
    return v;
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int b;
    b = first_byte(a, sz);
    for (int i = 0; i < span(sz); i++) model[b + i] = wd[8*i +: 8];
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: rd_data=%08h expected=%08h", tag, got, want);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, sample at the next falling edge
  task automatic op(input bit rd, input bit wr, input logic [1:0] sz,
                    input logic [31:0] a, input logic [31:0] wd, input string tag);
    rd_en = rd; wr_en = wr; acc_size = sz; addr = a; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    if (rd) exp_rd = model_load(a, sz);
    else if (wr) model_store(a, sz, wd);
    rd_en = 1'b0; wr_en = 1'b0;
    check(tag, rd_data, exp_rd);
  endtask

  function automatic string load_tag(input logic [1:0] sz);
    case (sz)
      2'b01: return "R3 half load";
      2'b10: return "R4 byte load";
      2'b11: return "R9 size 11 load";
      default: return "R2 word load";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset value", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", rd_data, 32'h0);

    // Fill every word so that later loads see known data
    for (int w = 0; w < NBYTES / 4; w++) op(1'b0, 1'b1, 2'b00, 32'(w * 4), $urandom, "R11 no load yet");

    // R1 size codes: 00 word, 01 half, 10 byte
    op(1'b0, 1'b1, 2'b00, 32'h40, 32'h11223344, "R5 store keeps rd_data");
    op(1'b1, 1'b0, 2'b00, 32'h43, 32'h0, "R2 word, low bits ignored");
    check("R2 word value", rd_data, 32'h11223344);
    op(1'b1, 1'b0, 2'b01, 32'h43, 32'h0, "R3 upper half");
    check("R3 upper half value", rd_data, 32'h00001122);
    op(1'b1, 1'b0, 2'b01, 32'h41, 32'h0, "R3 lower half");
    check("R3 lower half value", rd_data, 32'h00003344);
    op(1'b1, 1'b0, 2'b10, 32'h41, 32'h0, "R4 byte 1");
    check("R4 byte 1 value", rd_data, 32'h00000033);
    op(1'b1, 1'b0, 2'b10, 32'h43, 32'h0, "R4 byte 3");
    check("R4 byte 3 value", rd_data, 32'h00000011);
    op(1'b0, 1'b0, 2'b00, 32'h0, 32'h0, "R5 idle hold");
    check("R5 hold value", rd_data, 32'h00000011);
    op(1'b0, 1'b1, 2'b01, 32'h43, 32'hFFFFABCD, "R7 half store");
    op(1'b1, 1'b0, 2'b00, 32'h40, 32'h0, "R7 readback");
    check("R7 merged value", rd_data, 32'hABCD3344);
    op(1'b0, 1'b1, 2'b10, 32'h41, 32'h1234565A, "R8 byte store");
    op(1'b1, 1'b0, 2'b00, 32'h40, 32'h0, "R8 readback");
    check("R8 merged value", rd_data, 32'hABCD5A44);
    op(1'b0, 1'b1, 2'b11, 32'h7FFF_F442, 32'hCAFEF00D, "R10 aliased store");
    op(1'b1, 1'b0, 2'b11, 32'h40, 32'h0, "R9 size 11 readback");
    check("R9 R10 value", rd_data, 32'hCAFEF00D);
    op(1'b1, 1'b1, 2'b00, 32'h40, 32'h0, "R6 load wins");
    op(1'b1, 1'b0, 2'b00, 32'h40, 32'h0, "R6 memory unchanged");
    check("R6 unchanged value", rd_data, 32'hCAFEF00D);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  sel;
      logic [1:0]  sz;
      logic [31:0] a;
      logic [31:0] wd;
      sel = 2'($urandom);
      sz = 2'($urandom);
      a = $urandom;
      wd = $urandom;
      case (sel)
        2'd0: op(1'b1, 1'b0, sz, a, wd, load_tag(sz));
        2'd1: op(1'b0, 1'b1, sz, a, wd, sz == 2'b01 ? "R7 random store" : sz == 2'b10 ? "R8 random store" : "R5 random store");
        2'd2: op(1'b1, 1'b1, sz, a, wd, "R6 random load+store");
        default: op(1'b0, 1'b0, sz, a, wd, "R5 random idle");
      endcase
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule